// File: doc/BRIEF.md
# Two-Wire Slave Front End with Programming Lockout

This block is the serial front end of a register-based peripheral on a two-wire bus. It runs from a system clock many times faster than the bus clock. Both bus lines pass through a synchronizer and a majority filter before any edge is decoded. From the filtered lines it finds bus conditions, shifts in an eight-bit address byte and compares that byte against a fixed device-type nibble followed by four strap pins. When the address matches, it pulls SDA low in the acknowledge slot. Each following byte is passed to a command block with a one-cycle valid pulse and a byte index. The command block can ask for a byte to be returned to the host. That byte then goes out MSB first through the same open-drain pull-low enable.

When a STOP closes a transaction that the command block has flagged as a nonvolatile write, the front end enters a lockout for a fixed number of system clocks. During the lockout it acknowledges nothing, including its own address. The host can therefore poll for the end of programming by sending the address and looking for an acknowledge.

Top module: `twi_slave_lockout`

## Requirements
- R1: The address byte is acknowledged only when its upper nibble is 4'b0101 and its lower nibble equals strap_i (bit 0 of the byte compared with strap_i[0]). The acknowledge is a pull-low on sda_oe_o held through the ninth SCL pulse, asserted only while SCL is low.
- R2: After an address that does not match, the block gives no acknowledge and no byte_vld_o pulse until the next START.
- R3: Each byte written after a matched address produces one single-cycle byte_vld_o pulse. The byte arrives MSB first on byte_data_o. byte_idx_o is 0 for the first byte after the address and rises by one per byte. Every byte is acknowledged.
- R4: When rd_en_i is high at the end of an acknowledge slot, rd_data_i is sent MSB first. sda_oe_o is high only for zero bits and changes only while SCL is low.
- R5: If the host acknowledges a returned byte, the next byte is sent. If the host does not acknowledge, SDA is released and stays released until the next START or STOP.
- R6: A START in any state, including in the middle of a byte, restarts address reception and resets byte_idx_o to 0.
- R7: A STOP that ends a transaction with a matched address while nv_write_i is high holds nv_busy_o high for exactly LOCK_CYC system clocks. During that time a matching address gets no acknowledge and no byte is delivered. After the lockout ends, the address is acknowledged again.
- R8: A STOP with nv_write_i low, or a STOP ending a transaction whose address did not match, starts no lockout.
- R9: A pulse on SCL that lasts a single system clock is ignored and does not disturb a byte in progress.
- R10: While reset is held, and straight after it, sda_oe_o, byte_vld_o and nv_busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 4 | Address strap pins; strap_i[0] is the address LSB |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| byte_vld_o | output | 1 | One-cycle pulse for a received byte |
| byte_idx_o | output | IDX_W | Position of the byte after the address byte |
| byte_data_o | output | 8 | Received byte |
| rd_en_i | input | 1 | Command block requests that the next byte be sent |
| rd_data_i | input | 8 | Byte to send, sampled when it is loaded |
| nv_write_i | input | 1 | Current transaction writes nonvolatile storage |
| stop_o | output | 1 | One-cycle pulse on a STOP condition |
| nv_busy_o | output | 1 | Programming lockout active |

## Verification
The bound checker checks the following on every clock cycle. The pull-low enable never rises while filtered SCL is high. The lockout never overlaps a pull-low or a delivered byte. The lockout begins only on the cycle after a STOP and never lasts longer than LOCK_CYC. Byte pulses are single-cycle and never coincide with the block driving SDA. Other behaviours can only be shown by the bench scenarios:
- address matching against the strap pins;
- the exact data and index of each byte;
- the read sequence with host acknowledge and no-acknowledge;
- restart in the middle of a byte;
- polling during the lockout;
- rejection of a one-clock SCL glitch.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } twi_st_e;

  localparam logic [3:0] DEV_TYPE = 4'b0101;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int WIN         = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(WIN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [WIN-1:0]         win_q;
  logic [CW-1:0]          ones;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      win_q  <= '1;
      q_o    <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], d_i};
      win_q  <= {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
      q_o    <= (ones > CW'(WIN / 2));
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < WIN; i++) ones = ones + CW'(win_q[i]);
  end
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  assign scl_rise_o = scl_f_i & ~scl_q;
  assign scl_fall_o = ~scl_f_i & scl_q;
  // SDA edge with SCL high on both samples is a bus condition
  assign start_o    = scl_f_i & scl_q & sda_q & ~sda_f_i;
  assign stop_o     = scl_f_i & scl_q & ~sda_q & sda_f_i;
endmodule

// File: rtl/twi_lock_timer.sv
module twi_lock_timer #(
  parameter int LOCK_CYC = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= CW'(LOCK_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/twi_slave_lockout.sv
module twi_slave_lockout
  import twi_pkg::*;
#(
  parameter logic [3:0] DEV_ID      = DEV_TYPE,
  parameter int         LOCK_CYC    = 1000000,
  parameter int         IDX_W       = 4,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_WIN    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [3:0]       strap_i,
  output logic             sda_oe_o,
  output logic             byte_vld_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic [7:0]       byte_data_o,
  input  logic             rd_en_i,
  input  logic [7:0]       rd_data_i,
  input  logic             nv_write_i,
  output logic             stop_o,
  output logic             nv_busy_o
);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_c, stop_c;
  logic lock_load;

  twi_line_filter #(.SYNC_STAGES(SYNC_STAGES), .WIN(FILT_WIN)) u_flt_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_f)
  );
  twi_line_filter #(.SYNC_STAGES(SYNC_STAGES), .WIN(FILT_WIN)) u_flt_sda (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_f)
  );

  twi_cond_detect u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_f_i(scl_f), .sda_f_i(sda_f),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  twi_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(lock_load), .busy_o(nv_busy_o)
  );

  twi_st_e          state_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       rx_sh_q, tx_sh_q;
  logic             match_q, sel_q, ack_addr_q, mack_q, oe_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       rx_next;

  assign rx_next   = {rx_sh_q[6:0], sda_f};
  assign lock_load = stop_c & sel_q & nv_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '0;
      match_q     <= 1'b0;
      sel_q       <= 1'b0;
      ack_addr_q  <= 1'b0;
      mack_q      <= 1'b0;
      oe_q        <= 1'b0;
      idx_q       <= '0;
      byte_vld_o  <= 1'b0;
      byte_data_o <= '0;
      stop_o      <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      stop_o     <= stop_c;
      if (start_c) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        idx_q     <= '0;
        sel_q     <= 1'b0;
        oe_q      <= 1'b0;
      end else if (stop_c) begin
        state_q <= ST_IDLE;
        sel_q   <= 1'b0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE, ST_WAIT: ;
          ST_ADDR: begin
            if (scl_rise && bit_cnt_q < 4'd8) begin
              rx_sh_q   <= rx_next;
              bit_cnt_q <= bit_cnt_q + 4'd1;
              if (bit_cnt_q == 4'd7)
                match_q <= (rx_next == {DEV_ID, strap_i}) && !nv_busy_o;
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              if (match_q) begin
                state_q    <= ST_ACK;
                oe_q       <= 1'b1;
                sel_q      <= 1'b1;
                ack_addr_q <= 1'b1;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          ST_RX: begin
            if (scl_rise && bit_cnt_q < 4'd8) begin
              rx_sh_q   <= rx_next;
              bit_cnt_q <= bit_cnt_q + 4'd1;
              if (bit_cnt_q == 4'd7) begin
                byte_vld_o  <= 1'b1;
                byte_data_o <= rx_next;
              end
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              state_q    <= ST_ACK;
              oe_q       <= 1'b1;
              ack_addr_q <= 1'b0;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt_q <= '0;
              if (!ack_addr_q) idx_q <= idx_q + IDX_ONE;
              if (rd_en_i) begin
                state_q <= ST_TX;
                tx_sh_q <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
              end else begin
                state_q <= ST_RX;
                oe_q    <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt_q == 4'd8) begin
                state_q <= ST_TX_ACK;
                oe_q    <= 1'b0;
              end else begin
                tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                oe_q    <= ~tx_sh_q[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_f;
            end else if (scl_fall) begin
              if (mack_q) begin
                state_q   <= ST_TX;
                bit_cnt_q <= '0;
                idx_q     <= idx_q + IDX_ONE;
                tx_sh_q   <= rd_data_i;
                oe_q      <= ~rd_data_i[7];
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign byte_idx_o = idx_q;
endmodule

// File: rtl/twi_slave_chk.sv
module twi_slave_chk #(
  parameter int LOCK_CYC = 1000000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_f,
  input logic stop_c,
  input logic sda_oe_o,
  input logic nv_busy_o,
  input logic byte_vld_o
);
  int busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        busy_run <= 0;
    else if (nv_busy_o) busy_run <= busy_run + 1;
    else                busy_run <= 0;
  end

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_f); // R4
  AST_BUSY_NO_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_busy_o |-> !sda_oe_o); // R7
  AST_BUSY_NO_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_busy_o |-> !byte_vld_o); // R7
  AST_BUSY_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nv_busy_o) |-> $past(stop_c)); // R7
  AST_BUSY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= LOCK_CYC); // R7
  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o); // R3
  AST_VLD_NO_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> !sda_oe_o); // R3
endmodule

bind twi_slave_lockout twi_slave_chk #(.LOCK_CYC(LOCK_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_f(scl_f), .stop_c(stop_c),
  .sda_oe_o(sda_oe_o), .nv_busy_o(nv_busy_o), .byte_vld_o(byte_vld_o)
);

// File: tb/sim_twi_slave_lockout.sv
`timescale 1ns/1ps
module sim_twi_slave_lockout;
  localparam int LOCK = 3000;
  localparam int H    = 20;
  localparam int Q    = 5;
  localparam int NV   = 8;
  // {expect_ack, addr, byte0, byte1}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h5A, 8'h90, 8'h3F},
    {1'b0, 8'h5B, 8'h12, 8'h34},
    {1'b0, 8'hDA, 8'h56, 8'h78},
    {1'b1, 8'h5A, 8'h00, 8'hFF},
    {1'b0, 8'h4A, 8'h9A, 8'hBC},
    {1'b1, 8'h5A, 8'hA5, 8'h5A},
    {1'b0, 8'h7A, 8'hDE, 8'hF0},
    {1'b1, 8'h5A, 8'hC0, 8'h2B}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, scl_g = 1'b0;
  logic [3:0] strap = 4'b1010;
  logic sda_oe, byte_vld, stop_p, busy, nv_wr = 1'b0, rd_mode = 1'b0, got_instr = 1'b0;
  logic [3:0] byte_idx;
  logic [7:0] byte_data, rd_data;
  logic sda_line, scl_line, rd_en;
  int total = 0, bad = 0, cap_cnt = 0;
  logic [7:0] cap_data [4];
  logic [3:0] cap_idx [4];
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rd_val(input logic [3:0] i);
    return 8'hC6 ^ (8'(i) * 8'h3B);
  endfunction

  assign sda_line = sda_m & ~sda_oe;
  assign scl_line = scl_m & ~scl_g;
  assign rd_en    = rd_mode & got_instr;
  assign rd_data  = rd_val(byte_idx);

  twi_slave_lockout #(.LOCK_CYC(LOCK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .byte_vld_o(byte_vld),
    .byte_idx_o(byte_idx), .byte_data_o(byte_data), .rd_en_i(rd_en),
    .rd_data_i(rd_data), .nv_write_i(nv_wr), .stop_o(stop_p), .nv_busy_o(busy)
  );

  always @(negedge clk) if (byte_vld) begin
    if (cap_cnt < 4) begin
      cap_data[cap_cnt] = byte_data;
      cap_idx[cap_cnt]  = byte_idx;
    end
    if (byte_idx == 4'd0) got_instr = 1'b1;
    cap_cnt++;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(H); scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(H); scl_m = 1'b1; wclk(H); sda_m = 1'b1;
  endtask

  task automatic send_bit(input logic b, input bit g);
    sda_m = b; wclk(H); scl_m = 1'b1; wclk(H / 2);
    if (g) begin scl_g = 1'b1; wclk(1); scl_g = 1'b0; wclk(H / 2 - 1); end
    else wclk(H / 2);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; wclk(H); scl_m = 1'b1; wclk(H / 2);
    b = sda_line; wclk(H / 2); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit g, output bit ack);
    logic nb;
    for (int i = 7; i >= 0; i--) send_bit(d[i], g);
    read_bit(nb);
    ack = !nb;
  endtask

  task automatic read_byte(input logic host_bit, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) read_bit(d[i]);
    send_bit(host_bit, 1'b0);
  endtask

  task automatic new_frame();
    cap_cnt = 0; got_instr = 1'b0;
    bus_start();
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    int n;
    wclk(3);
    chk(sda_oe == 0 && busy == 0 && byte_vld == 0, "R10 in reset", {sda_oe, busy, byte_vld}, 0);
    rst_n = 1'b1; wclk(10);
    chk(sda_oe == 0 && busy == 0 && byte_vld == 0, "R10 after reset", {sda_oe, busy, byte_vld}, 0);

    // table walk: R1 R2 R3
    for (int v = 0; v < NV; v++) begin
      new_frame();
      send_byte(VEC[v][23:16], 1'b0, ack);
      chk(ack == VEC[v][24], "R1 address ack", ack, VEC[v][24]);
      send_byte(VEC[v][15:8], 1'b0, ack);
      chk(ack == VEC[v][24], "R2/R3 byte0 ack", ack, VEC[v][24]);
      send_byte(VEC[v][7:0], 1'b0, ack);
      bus_stop(); wclk(H);
      if (VEC[v][24]) begin
        chk(cap_cnt == 2, "R3 byte count", cap_cnt, 2);
        chk(cap_data[0] == VEC[v][15:8] && cap_idx[0] == 0, "R3 byte0", {cap_idx[0], cap_data[0]}, {4'd0, VEC[v][15:8]});
        chk(cap_data[1] == VEC[v][7:0] && cap_idx[1] == 1, "R3 byte1", {cap_idx[1], cap_data[1]}, {4'd1, VEC[v][7:0]});
      end else begin
        chk(cap_cnt == 0, "R2 no bytes after mismatch", cap_cnt, 0);
      end
      chk(busy == 0, "R8 no lockout without nv flag", busy, 0);
    end

    // R4 R5 read sequence
    rd_mode = 1'b1;
    new_frame();
    send_byte(8'h5A, 1'b0, ack);
    send_byte(8'h9C, 1'b0, ack);
    read_byte(1'b0, d);
    chk(d == rd_val(0), "R4 first read byte", d, rd_val(0));
    read_byte(1'b1, d);
    chk(d == rd_val(1), "R5 byte after host ack", d, rd_val(1));
    read_byte(1'b1, d);
    chk(d == 8'hFF, "R5 released after no-ack", d, 8'hFF);
    bus_stop(); wclk(H);
    rd_mode = 1'b0;

    // R6 repeated start after mismatch
    new_frame();
    send_byte(8'h5B, 1'b0, ack);
    chk(!ack, "R6 first address rejected", ack, 0);
    bus_start();
    send_byte(8'h5A, 1'b0, ack);
    chk(ack, "R6 restart address ack", ack, 1);
    send_byte(8'h11, 1'b0, ack);
    bus_stop(); wclk(H);
    chk(cap_cnt == 1 && cap_data[0] == 8'h11, "R6 byte after restart", cap_data[0], 8'h11);

    // R6 restart mid-byte
    new_frame();
    send_byte(8'h5A, 1'b0, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    cap_cnt = 0;
    bus_start();
    send_byte(8'h5A, 1'b0, ack);
    send_byte(8'h77, 1'b0, ack);
    bus_stop(); wclk(H);
    chk(cap_cnt == 1 && cap_data[0] == 8'h77 && cap_idx[0] == 0, "R6 mid-byte restart", {cap_idx[0], cap_data[0]}, 8'h77);

    // R9 glitch on SCL high phase
    new_frame();
    send_byte(8'h5A, 1'b0, ack);
    send_byte(8'h5C, 1'b1, ack);
    bus_stop(); wclk(H);
    chk(ack && cap_cnt == 1 && cap_data[0] == 8'h5C, "R9 glitch ignored", cap_data[0], 8'h5C);

    // R8 nv flag with mismatched address
    nv_wr = 1'b1;
    new_frame();
    send_byte(8'h5B, 1'b0, ack);
    bus_stop(); wclk(H);
    chk(busy == 0, "R8 no lockout on unselected frame", busy, 0);

    // R7 lockout length
    new_frame();
    send_byte(8'h5A, 1'b0, ack);
    send_byte(8'h42, 1'b0, ack);
    bus_stop();
    n = 0;
    while (!busy && n < 100) begin wclk(1); n++; end
    n = 0;
    while (busy) begin n++; wclk(1); end
    chk(n == LOCK, "R7 lockout length", n, LOCK);

    // R7 polling during lockout
    new_frame();
    send_byte(8'h5A, 1'b0, ack);
    send_byte(8'h43, 1'b0, ack);
    bus_stop(); wclk(H);
    nv_wr = 1'b0;
    new_frame();
    send_byte(8'h5A, 1'b0, ack);
    chk(!ack, "R7 no ack while busy", ack, 0);
    send_byte(8'h44, 1'b0, ack);
    bus_stop(); wclk(H);
    chk(busy == 1 && cap_cnt == 0, "R7 ignored during lockout", {busy, cap_cnt[3:0]}, 5'h10);
    while (busy) wclk(1);
    new_frame();
    send_byte(8'h5A, 1'b0, ack);
    chk(ack, "R7 ack after lockout", ack, 1);
    bus_stop(); wclk(H);
    chk(busy == 0, "R8 no lockout with nv flag low", busy, 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule